// File: doc/BRIEF.md
# Dual-Mode Timer and Event Counter

This peripheral holds one up-counter that serves two uses. In event mode it counts chosen edges on an external input line. In capture mode it measures how long a single pulse on that line lasts. The count source in capture mode is the system clock, slowed by a power-of-two prescaler.

Software sets the block up through a small write port. The port reaches a control register and a preload register. A read port returns either the running count or the control register. When the counter wraps from all ones, it reloads from the preload register. It then sets a sticky overflow flag and raises a one-cycle interrupt request, provided the interrupt enable input is high. If the system reports that it is asleep when the overflow happens, the block also emits a one-cycle wake strobe.

The external line is asynchronous. A two-flop synchroniser brings it into the clock domain, and edge detection follows.

Top module: `pulse_event_timer`

## Requirements
- R1: After reset the count, the preload value and the control register all read 0. The interrupt, wake and overflow flag outputs are all 0.
- R2: The control register is one byte. Bits [7:6] select the mode: 01 is event counting and 11 is pulse capture. Bit 4 is the run bit, bit 3 is the polarity bit and bits [2:0] are the prescale rate. Bit 5 always reads 0. Writes use wr_sel=0 for control and wr_sel=1 for preload. Reads use rd_sel=0 for the count and rd_sel=1 for control.
- R3: In event mode with run set, each rising edge of the pin adds exactly one to the count when the polarity bit is 0. Each falling edge adds one when it is 1. No prescaling applies, and the opposite edge has no effect.
- R4: A count step taken at all ones loads the preload value into the counter, sets the overflow flag and makes irq high for exactly one cycle.
- R5: When irq_en is low, an overflow still sets the flag but produces no irq pulse.
- R6: The overflow flag stays set until ovf_clr is asserted. An overflow in the same cycle as ovf_clr leaves the flag set.
- R7: An overflow while sleep is high produces one wake pulse of one cycle.
- R8: Writing the preload register while the run bit is 0 also loads the counter. While the run bit is 1, the same write leaves the count unchanged and only takes effect at the next reload.
- R9: In capture mode, setting the run bit only arms the block. The count does not move until the starting edge arrives.
- R10: In capture mode, polarity 0 starts counting on a falling edge and stops on the next rising edge. Polarity 1 starts on a rising edge and stops on a falling edge. A pulse N clock cycles long adds floor(N / 2^rate) to the count.
- R11: At the end of a captured pulse the run bit clears itself. The count then holds its value until software acts.
- R12: With mode 00 or 10 the count never changes on pin activity, even when the run bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_pin | input | 1 | External timer line, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 preload |
| wr_data | input | 8 | Write data |
| rd_sel | input | 1 | Read source: 0 count, 1 control |
| rd_data | output | 8 | Read data, combinational |
| irq_en | input | 1 | Interrupt enable |
| ovf_clr | input | 1 | Software clear of the overflow flag |
| sleep | input | 1 | High while the system is idle or asleep |
| irq | output | 1 | One-cycle interrupt request on overflow |
| wake | output | 1 | One-cycle wake strobe on overflow during sleep |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The counter sets the overflow flag, and software clears it through ovf_clr. Both can land on the same clock edge. The bench holds ovf_clr high with the count at all ones, then raises the pin, so that the synchronised edge and the clear meet three edges later. It samples the flag in exactly that cycle and expects it set, then expects it cleared one cycle later, because the clear is still held and no new overflow occurs.

// File: rtl/pet_pkg.sv
package pet_pkg;

    localparam int RATE_W = 3;
    localparam int CTRL_W = 8;

    typedef enum logic [1:0] {
        MODE_IDLE0   = 2'b00,
        MODE_EVENT   = 2'b01,
        MODE_IDLE2   = 2'b10,
        MODE_CAPTURE = 2'b11
    } pet_mode_e;

    typedef struct packed {
        pet_mode_e         mode;
        logic              run;
        logic              pol;
        logic [RATE_W-1:0] rate;
    } pet_ctrl_t;

    function automatic pet_ctrl_t pet_decode(input logic [CTRL_W-1:0] b);
        pet_ctrl_t c;
        c.mode = pet_mode_e'(b[7:6]);
        c.run  = b[4];
        c.pol  = b[3];
        c.rate = b[2:0];
        return c;
    endfunction

    function automatic logic [CTRL_W-1:0] pet_encode(input pet_ctrl_t c);
        return {c.mode, 1'b0, c.run, c.pol, c.rate};
    endfunction

endpackage

// File: rtl/pet_edge_sync.sv
module pet_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q, sync_d;
    logic              prev_q, prev_d;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = pin_async;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], pin_async};
        end
    endgenerate

    always_comb prev_d = sync_q[LAST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign rise = sync_q[LAST] & ~prev_q;
    assign fall = ~sync_q[LAST] & prev_q;

endmodule

// File: rtl/pet_prescaler.sv
module pet_prescaler #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int PW = (1 << RATE_W) - 1;

    logic [PW-1:0] div_q, div_d;
    logic [PW-1:0] limit;

    always_comb begin
        limit = (PW'(1) << rate) - PW'(1);
        tick  = en && (div_q == limit);
        if (clr || !en || tick) div_d = '0;
        else                    div_d = div_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R10: a cleared prescaler restarts from zero
    a_r10_clr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (div_q == '0));

endmodule

// File: rtl/pulse_event_timer.sv
module pulse_event_timer #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_pin,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [CNT_W-1:0] rd_data,
    input  logic             irq_en,
    input  logic             ovf_clr,
    input  logic             sleep,
    output logic             irq,
    output logic             wake,
    output logic             ovf_flag
);
    import pet_pkg::*;

    typedef struct packed {
        pet_ctrl_t        ctrl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] preload;
        logic             active;
        logic             flag;
        logic             irq;
        logic             wake;
    } state_t;

    state_t state_q, state_d;

    logic pin_rise, pin_fall, psc_tick;
    logic start_edge, end_edge, count_edge;
    logic step, ovf;
    logic wr_ctrl, wr_pre;
    pet_ctrl_t new_ctrl;

    pet_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (tmr_pin),
        .rise      (pin_rise),
        .fall      (pin_fall)
    );

    pet_prescaler #(.RATE_W(RATE_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!state_q.active),
        .en    (state_q.active),
        .rate  (state_q.ctrl.rate),
        .tick  (psc_tick)
    );

    always_comb begin
        start_edge = state_q.ctrl.pol ? pin_rise : pin_fall;
        end_edge   = state_q.ctrl.pol ? pin_fall : pin_rise;
        count_edge = state_q.ctrl.pol ? pin_fall : pin_rise;
        wr_ctrl    = wr_en && !wr_sel;
        wr_pre     = wr_en && wr_sel;
        new_ctrl   = pet_decode(wr_data[CTRL_W-1:0]);
    end

    always_comb begin
        state_d      = state_q;
        state_d.irq  = 1'b0;
        state_d.wake = 1'b0;
        step         = 1'b0;
        ovf          = 1'b0;

        case (state_q.ctrl.mode)
            MODE_EVENT: begin
                if (state_q.ctrl.run && count_edge) step = 1'b1;
            end
            MODE_CAPTURE: begin
                if (state_q.ctrl.run) begin
                    if (!state_q.active) begin
                        if (start_edge) state_d.active = 1'b1;
                    end else begin
                        if (psc_tick) step = 1'b1;
                        if (end_edge) begin
                            state_d.active   = 1'b0;
                            state_d.ctrl.run = 1'b0;
                        end
                    end
                end
            end
            default: ;
        endcase

        if (step) begin
            if (state_q.cnt == '1) begin
                state_d.cnt = state_q.preload;
                ovf         = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt + CNT_W'(1);
            end
        end

        if (ovf) begin
            state_d.irq  = irq_en;
            state_d.wake = sleep;
        end

        if (ovf_clr) state_d.flag = 1'b0;
        if (ovf)     state_d.flag = 1'b1;

        if (wr_ctrl) state_d.ctrl = new_ctrl;
        if (wr_pre) begin
            state_d.preload = wr_data;
            if (!state_q.ctrl.run) state_d.cnt = wr_data;
        end

        if (state_d.ctrl.mode != MODE_CAPTURE || !state_d.ctrl.run)
            state_d.active = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rd_data  = rd_sel ? CNT_W'(pet_encode(state_q.ctrl)) : state_q.cnt;
    assign irq      = state_q.irq;
    assign wake     = state_q.wake;
    assign ovf_flag = state_q.flag;

    // R5: an interrupt pulse only follows a cycle with the enable high
    a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en));

    // R6: the flag stays set until software clears it
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R7: a wake strobe only follows a sleeping cycle
    a_r7_wake_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> $past(sleep));

    // R9: an armed capture that has seen no start edge holds the count
    a_r9_armed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ctrl.mode == MODE_CAPTURE && state_q.ctrl.run &&
         !state_q.active && !wr_pre) |=> $stable(state_q.cnt));

    // R11: the end of a captured pulse clears the run bit
    a_r11_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.ctrl.mode == MODE_CAPTURE && state_q.active && end_edge && !wr_ctrl)
        |=> !state_q.ctrl.run);

    // R12: idle modes never move the count except by a preload write
    a_r12_idle_modes: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q.ctrl.mode == MODE_IDLE0 || state_q.ctrl.mode == MODE_IDLE2) && !wr_pre)
        |=> $stable(state_q.cnt));

endmodule

// File: tb/pulse_event_timer_bench.sv
module pulse_event_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       irq_en = 1'b0;
    logic       ovf_clr = 1'b0;
    logic       sleep = 1'b0;
    logic       irq, wake, ovf_flag;

    int tests = 0;
    int fails = 0;
    int irq_seen = 0;
    int wake_seen = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pulse_event_timer u_pulse_event_timer (
        .clk(clk), .rst_n(rst_n), .tmr_pin(tmr_pin),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_en(irq_en), .ovf_clr(ovf_clr), .sleep(sleep),
        .irq(irq), .wake(wake), .ovf_flag(ovf_flag)
    );

    always @(negedge clk) begin
        if (irq)  irq_seen++;
        if (wake) wake_seen++;
    end

    function automatic logic [7:0] exp_capture(input int n, input int rate);
        return 8'((n >> rate) & 255);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        rd_sel = sel;
        #1 v = rd_data;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_to(input logic v);
        @(negedge clk);
        tmr_pin = v;
        settle(4);
    endtask

    task automatic pulse_pin();
        pin_to(1'b1);
        pin_to(1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=hang expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int k, n, r, base;
        logic p;
        void'($urandom(32'd917));

        settle(3);
        // R1: reset state
        rd(1'b0, v); check("R1 count", v, 0);
        rd(1'b1, v); check("R1 control", v, 0);
        check("R1 outputs", {irq, wake, ovf_flag}, 0);
        rst_n = 1'b1;
        settle(2);
        rd(1'b0, v); check("R1 count after release", v, 0);

        // R2: layout and reserved bit
        wr(1'b0, 8'h7B);
        rd(1'b1, v); check("R2 control readback", v, 8'h5B);
        wr(1'b0, 8'h00);

        // R8: preload loads the counter while stopped
        wr(1'b1, 8'h10);
        rd(1'b0, v); check("R8 load when stopped", v, 8'h10);

        // R3: rising edges, random count
        wr(1'b0, 8'h50);
        k = 1 + ($urandom % 20);
        for (int i = 0; i < k; i++) pulse_pin();
        rd(1'b0, v); check("R3 rising edges counted", v, 8'(16 + k));

        // R3: falling polarity, rising edge ignored
        base = 16 + k;
        wr(1'b0, 8'h58);
        pin_to(1'b1);
        rd(1'b0, v); check("R3 rising ignored with pol 1", v, base);
        pin_to(1'b0);
        rd(1'b0, v); check("R3 falling counted with pol 1", v, base + 1);

        // R4 and R8: overflow reload with preload changed while running
        wr(1'b0, 8'h00);
        wr(1'b1, 8'hFE);
        irq_en = 1'b1;
        wr(1'b0, 8'h50);
        wr(1'b1, 8'h20);
        rd(1'b0, v); check("R8 running write keeps count", v, 8'hFE);
        pulse_pin();
        rd(1'b0, v); check("R4 reaches all ones", v, 8'hFF);
        check("R4 no early flag", ovf_flag, 0);
        base = irq_seen;
        pulse_pin();
        rd(1'b0, v); check("R4 reload from preload", v, 8'h20);
        check("R4 flag set", ovf_flag, 1);
        check("R4 single irq pulse", irq_seen - base, 1);
        check("R7 no wake when awake", wake_seen, 0);

        // R6: flag held, then cleared
        settle(10);
        check("R6 flag held", ovf_flag, 1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        check("R6 flag cleared", ovf_flag, 0);

        // R5, R7, R6: gated irq, wake, set beats clear in the same cycle
        wr(1'b0, 8'h00);
        wr(1'b1, 8'hFF);
        irq_en = 1'b0;
        sleep = 1'b1;
        wr(1'b0, 8'h50);
        base = irq_seen;
        @(negedge clk);
        ovf_clr = 1'b1;
        tmr_pin = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R6 set wins over clear", ovf_flag, 1);
        rd(1'b0, v); check("R4 reload all ones", v, 8'hFF);
        @(negedge clk);
        check("R6 clear next cycle", ovf_flag, 0);
        ovf_clr = 1'b0;
        sleep = 1'b0;
        settle(3);
        check("R5 no irq when disabled", irq_seen - base, 0);
        check("R7 one wake pulse", wake_seen, 1);
        pin_to(1'b0);

        // R12: idle modes ignore the pin
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h05);
        wr(1'b0, 8'h10);
        pulse_pin(); pulse_pin();
        wr(1'b0, 8'h90);
        pulse_pin();
        rd(1'b0, v); check("R12 idle modes hold", v, 5);

        // R9, R10, R11: capture with random widths and rates
        for (int it = 0; it < 8; it++) begin
            p = it[0];
            r = (it < 2) ? 0 : int'($urandom % 8);
            n = (it == 2) ? 1 : 5 + int'($urandom % 180);
            wr(1'b0, 8'h00);
            pin_to(~p);
            wr(1'b1, 8'h00);
            wr(1'b0, 8'(8'hD0 | (p << 3) | r));
            settle(6);
            rd(1'b0, v); check("R9 armed count idle", v, 0);
            @(negedge clk);
            tmr_pin = p;
            repeat (n) @(negedge clk);
            tmr_pin = ~p;
            settle(6);
            rd(1'b0, v); check("R10 captured width", v, exp_capture(n, r));
            rd(1'b1, v); check("R11 run cleared", v, 8'(8'hC0 | (p << 3) | r));
            pulse_pin();
            rd(1'b0, v); check("R11 count holds", v, exp_capture(n, r));
        end

        finish_run();
    end

endmodule